// File: doc/BRIEF.md
# Shift-Window Synchronous FIFO

This block is a single-clock, eight-deep first-in first-out queue. Its storage is a shift register instead of a circular buffer. Every accepted write moves all stored words one stage toward the old end and places the new word in the newest stage. Stage 8 holds the newest word and stage 1 the oldest. One occupancy counter says how many stored words are live. The read position follows from that count (depth plus one, minus the count, held inside 1..8), so the design has no read pointer and no write pointer.

The producer raises a write strobe together with the data word. The consumer looks at the read data and raises a pop request to take it. The read data always shows the oldest live word. When the queue is empty and a write arrives, the incoming word passes straight through to the read data in the same cycle. A write into a full queue is dropped unless a pop happens in the same cycle. A pop from an empty queue is dropped unless a write happens in the same cycle.

Top module: `shift_window_fifo`

## Requirements
- R1: A clock edge with `rst` high clears the queue, and this takes priority over a write or pop in the same cycle. Afterwards `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: An accepted write with no accepted pop adds one entry. An accepted pop with no accepted write removes one entry.
- R3: When a write and a pop are both accepted in one cycle, the number of entries stays the same. The popped word is the oldest one and the written word joins at the new end. This also holds when the queue is full.
- R4: `full` is 1 exactly when 8 entries are held. `empty` is 1 exactly when 0 entries are held.
- R5: A write while full with no pop is ignored. The stored words, their order and the count stay unchanged.
- R6: A pop while empty with no write is ignored. The queue stays empty.
- R7: While the queue is not empty, `rd_data` shows the oldest held word. Popped words come out in the order they were accepted.
- R8: While empty, a write makes `rd_data` equal `wr_data` in the same cycle. A pop in that cycle takes that word, and the queue stays empty.
- R9: While empty with no write, `rd_data` shows the most recently accepted word, because the read position is clamped to the newest stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DW | Word to enqueue |
| pop_req | input | 1 | Take the word shown on `rd_data` |
| rd_data | output | DW | Oldest live word (pass-through when empty and writing) |
| full | output | 1 | Eight entries held |
| empty | output | 1 | No entries held |

## Verification
A write and a pop can land in the same cycle, and the two sensitive cases are at the edges of occupancy. When the queue is empty, the word has to pass straight through. When it is full, the oldest word must leave while the new word enters and the count stays at eight. The bench forces both cases with directed fill, drain and simultaneous runs, and then with random traffic biased toward each end. A scoreboard queue predicts which operations are accepted and which word each pop must return, and it checks both flags every cycle.

// File: rtl/swf_pkg.sv
package swf_pkg;

    // What the occupancy counter does in a cycle
    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_PUSH = 2'b01,
        OCC_POP  = 2'b10,
        OCC_SWAP = 2'b11
    } occ_op_e;

    // Accepted operations in the current cycle
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } grant_t;

    function automatic occ_op_e classify(input grant_t g);
        case ({g.push_ok, g.pop_ok})
            2'b10:   return OCC_PUSH;
            2'b01:   return OCC_POP;
            2'b11:   return OCC_SWAP;
            default: return OCC_HOLD;
        endcase
    endfunction

    // Keep a read position inside stage range 1..hi
    function automatic int clamp_tap(input int raw, input int hi);
        if (raw < 1)  return 1;
        if (raw > hi) return hi;
        return raw;
    endfunction

endpackage

// File: rtl/swf_occupancy.sv
module swf_occupancy
    import swf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output grant_t        grant
);

    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE   = CW'(1);

    occ_op_e op;

    always_comb begin
        full          = (count >= LIMIT);
        empty         = (count == '0);
        // A write into a full queue only goes through if a pop frees a slot
        grant.push_ok = push_req && (!full || pop_req);
        // A pop from an empty queue only goes through as a pass-through
        grant.pop_ok  = pop_req && (!empty || push_req);
        op            = classify(grant);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (op)
                OCC_PUSH: count <= count + ONE;
                OCC_POP:  count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/swf_window.sv
module swf_window #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic [DW-1:0]       din,
    output logic [DEPTH*DW-1:0] window
);

    localparam int WBITS = DEPTH * DW;

    // Stage k (1 = oldest, DEPTH = newest) sits at bits [(k-1)*DW +: DW]
    logic [WBITS-1:0] win_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           win_q <= '0;
                else if (shift_en) win_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)           win_q <= '0;
                else if (shift_en) win_q <= {din, win_q[WBITS-1:DW]};
            end
        end
    endgenerate

    assign window = win_q;

endmodule

// File: rtl/swf_tap.sv
module swf_tap
    import swf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]       count,
    input  logic                pass_through,
    input  logic [DW-1:0]       din,
    input  logic [DEPTH*DW-1:0] window,
    output logic [DW-1:0]       dout
);

    localparam int TW = CW + 1;

    int            raw_pos;
    logic [TW-1:0] tap;
    logic [DW-1:0] picked;

    always_comb begin
        // Oldest live word is at depth+1-count; clamp keeps empty on newest
        raw_pos = DEPTH + 1 - int'(count);
        tap     = TW'(clamp_tap(raw_pos, DEPTH));
        picked  = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            if (tap == TW'(k)) picked = window[(k-1)*DW +: DW];
        end
        dout = pass_through ? din : picked;
    end

endmodule

// File: rtl/shift_window_fifo.sv
module shift_window_fifo
    import swf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_req,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]       occ_count;
    logic                occ_full;
    logic                occ_empty;
    grant_t              grant;
    logic [DEPTH*DW-1:0] window;

    swf_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .push_req (wr_valid),
        .pop_req  (pop_req),
        .count    (occ_count),
        .full     (occ_full),
        .empty    (occ_empty),
        .grant    (grant)
    );

    swf_window #(.DW(DW), .DEPTH(DEPTH)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (grant.push_ok),
        .din      (wr_data),
        .window   (window)
    );

    swf_tap #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tap (
        .count        (occ_count),
        .pass_through (occ_empty && grant.push_ok),
        .din          (wr_data),
        .window       (window),
        .dout         (rd_data)
    );

    assign full  = occ_full;
    assign empty = occ_empty;

endmodule

// File: rtl/swf_checker.sv
module swf_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr,
    input logic          pop,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] occ
);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (empty && !full));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !pop && !full) |=> (occ == $past(occ) + CW'(1)));

    p_pop_shrinks_r2: assert property (@(posedge clk) disable iff (rst)
        (pop && !wr && !empty) |=> (occ == $past(occ) - CW'(1)));

    p_swap_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && pop) |=> $stable(occ));

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !pop) |=> (full && $stable(occ)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !wr) |=> empty);

    p_pass_through_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && wr) |-> (dout == din));

endmodule

bind shift_window_fifo swf_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_valid),
    .pop   (pop_req),
    .din   (wr_data),
    .dout  (rd_data),
    .full  (full),
    .empty (empty),
    .occ   (occ_count)
);

// File: tb/sim_shift_window_fifo.sv
`timescale 1ns/1ps
module sim_shift_window_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] rd_data;
    logic          full;
    logic          empty;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    mon_on = 1'b0;
    string tag    = "R1";

    logic [DW-1:0] sb_q[$];
    logic [DW-1:0] last_w = '0;

    always #2.5 clk = ~clk;

    shift_window_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .pop_req  (pop_req),
        .rd_data  (rd_data),
        .full     (full),
        .empty    (empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic w, input logic p, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = w;
        pop_req  = p;
        wr_data  = d;
    endtask

    // Monitor: samples mid-cycle, predicts acceptance, pops and compares
    always begin
        @(negedge clk);
        #1;
        if (mon_on) begin
            if (rst) begin
                sb_q.delete();
                last_w = '0;
            end else begin
                bit wa;
                bit pa;
                logic [DW-1:0] exp_w;
                chk(empty === (sb_q.size() == 0), tag, "R4 empty", 32'(empty), 32'(sb_q.size() == 0));
                chk(full === (sb_q.size() == DEPTH), tag, "R4 full", 32'(full), 32'(sb_q.size() == DEPTH));
                wa = wr_valid && (sb_q.size() < DEPTH || pop_req);
                pa = pop_req && (sb_q.size() > 0 || wr_valid);
                if (sb_q.size() == 0 && wr_valid)
                    chk(rd_data === wr_data, "R8", "pass-through", 32'(rd_data), 32'(wr_data));
                else if (sb_q.size() == 0)
                    chk(rd_data === last_w, "R9", "idle empty shows newest", 32'(rd_data), 32'(last_w));
                if (pa) begin
                    exp_w = (sb_q.size() > 0) ? sb_q[0] : wr_data;
                    chk(rd_data === exp_w, tag, "R7 popped word", 32'(rd_data), 32'(exp_w));
                end
                if (wa) begin
                    sb_q.push_back(wr_data);
                    last_w = wr_data;
                end
                if (pa) void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mon_on = 1'b1;
        // R1: reset with a write pending must still leave the queue empty
        drive(1'b1, 1'b0, 8'hA7);
        drive(1'b1, 1'b1, 8'hB3);
        drive(1'b0, 1'b0, 8'h00);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(empty === 1'b1 && full === 1'b0, "R1", "flags after reset", {30'd0, full, empty}, 32'd1);
        chk(rd_data === '0, "R1", "data after reset", 32'(rd_data), 32'd0);
        tag = "R1";
        drive(1'b0, 1'b0, 8'h00);

        tag = "R6";
        repeat (3) drive(1'b0, 1'b1, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        tag = "R8";
        drive(1'b1, 1'b1, 8'h5A);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b1, 1'b0, 8'h3C);
        drive(1'b0, 1'b1, 8'h00);

        tag = "R2";
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 8'(8'h10 + i));
        drive(1'b0, 1'b1, 8'h00);
        drive(1'b0, 1'b1, 8'h00);

        tag = "R3";
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 8'(8'h20 + i));

        tag = "R4";
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 8'(8'h30 + i));
        drive(1'b0, 1'b0, 8'h00);

        tag = "R5";
        drive(1'b1, 1'b0, 8'hEE);
        drive(1'b1, 1'b0, 8'hEF);
        drive(1'b0, 1'b0, 8'h00);

        tag = "R3";
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 8'(8'h40 + i));

        tag = "R7";
        for (int i = 0; i < 9; i++) drive(1'b0, 1'b1, 8'h00);

        tag = "R9";
        repeat (3) drive(1'b0, 1'b0, 8'h00);

        tag = "R7";
        for (int i = 0; i < 4500; i++) begin
            int wp;
            int pp;
            wp = (i < 1500) ? 75 : (i < 3000) ? 25 : 50;
            pp = (i < 1500) ? 30 : (i < 3000) ? 75 : 50;
            drive(($urandom % 100) < wp, ($urandom % 100) < pp, 8'($urandom));
        end
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule